// File: doc/BRIEF.md
# Single-Clock Two-Port RAM with Ordered Collisions

This block models a large on-chip memory with two access ports that run on one shared clock. In each cycle each port does at most one thing: it reads one word or writes one word, as its write-enable selects. When both ports touch the memory in the same cycle, the port A access is applied first and the port B access second. A collision between the two ports therefore always gives the same result.

Read data leaves through an output pipeline whose depth is a parameter between one and four cycles. Each pipeline stage carries a valid flag, so every read produces exactly one valid pulse, aligned with its data. The read-data output changes only when a read completes. It keeps its last value through write cycles and idle cycles. Reset clears the pipeline and valid flags but not the stored words. The default organisation is 4096 words of 72 bits, 288 Kb in total.

Top module: `ordram_top`

## Requirements
- R1: A word written through either port is returned by a later read of that address through either port.
- R2: A port whose enable is low in a cycle neither reads nor writes; with the enable high, write-enable high selects a write and low selects a read, never both.
- R3: For a read sampled at clock edge k, the port's read-valid output is high for exactly the one cycle after edge k+RD_LAT-1, where RD_LAT (1 to 4) is a parameter, and is low at all other times.
- R4: Read data changes only when read-valid is high; through write and idle cycles it keeps the value of the last completed read.
- R5: When port A writes an address that port B reads in the same cycle, port B returns port A's new data.
- R6: When port B writes an address that port A reads in the same cycle, port A returns the data stored before that cycle.
- R7: When both ports write the same address in the same cycle, port B's data is the value that remains stored.
- R8: A synchronous active-high reset drives both read-valid outputs low and both read-data outputs to zero on the next edge, and drops reads that are still in flight.
- R9: Accesses on the two ports to different addresses in the same cycle proceed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the output pipeline |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write-enable (1 write, 0 read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, held between reads |
| a_rvalid | output | 1 | Port A read data valid, one pulse per read |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write-enable (1 write, 0 read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, held between reads |
| b_rvalid | output | 1 | Port B read data valid, one pulse per read |

## Verification
The bench sweeps every address of a 16-word, 8-bit configuration and drives two instances, one with one cycle of latency and one with three, from the same stimulus. For each read it checks the valid pulse on every cycle of the window. A design with a wrong stage count would pulse early or late, or twice. The same-address collision cases are swept over all addresses: a port B read that saw stale data, a port A read that saw port B's new word, or a double write that left port A's data stored would each show up as a data mismatch. Idle and write cycles are checked for held read data, which catches a pipeline that passes data through without its valid flag. Accesses with the enable low and a reset during use are checked through later reads and the cleared outputs.

// File: rtl/ordram_pkg.sv
package ordram_pkg;

  localparam int LAT_MIN = 1;
  localparam int LAT_MAX = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e op_decode(input logic en, input logic we);
    if (!en)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/ordram_core.sv
module ordram_core
  import ordram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  port_op_e          a_op,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  port_op_e          b_op,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_q,
  output logic              a_qv,
  output logic [DATA_W-1:0] b_q,
  output logic              b_qv
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic a_wr, b_wr, a_rd, b_rd, a_to_b_fwd;

  assign a_wr       = (a_op == OP_WRITE);
  assign b_wr       = (b_op == OP_WRITE);
  assign a_rd       = (a_op == OP_READ);
  assign b_rd       = (b_op == OP_READ);
  // Port A goes first, so a port B read sees a same-cycle port A write.
  assign a_to_b_fwd = a_wr && (a_addr == b_addr);

  // Storage: port B write is issued last, so it wins a same-address tie.
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  // Port A first stage: reads the contents from before this cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      a_qv <= 1'b0;
    end else begin
      a_qv <= a_rd;
      if (a_rd) a_q <= mem[a_addr];
    end
  end

  // Port B first stage: observes port A's write of the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      b_q  <= '0;
      b_qv <= 1'b0;
    end else begin
      b_qv <= b_rd;
      if (b_rd) b_q <= a_to_b_fwd ? a_wdata : mem[b_addr];
    end
  end

endmodule

// File: rtl/ordram_rdpipe.sv
module ordram_rdpipe #(
  parameter int DATA_W = 72,
  parameter int STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign out_vld  = in_vld;
      assign out_data = in_data;
    end else begin : g_stages
      logic [DATA_W-1:0] stg_d [STAGES];
      logic              stg_v [STAGES];

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [DATA_W-1:0] src_d;
        logic              src_v;
        if (s == 0) begin : g_head
          assign src_d = in_data;
          assign src_v = in_vld;
        end else begin : g_body
          assign src_d = stg_d[s-1];
          assign src_v = stg_v[s-1];
        end

        // Data loads only with a valid read, so outputs hold otherwise.
        always_ff @(posedge clk) begin
          if (rst) begin
            stg_d[s] <= '0;
            stg_v[s] <= 1'b0;
          end else begin
            stg_v[s] <= src_v;
            if (src_v) stg_d[s] <= src_d;
          end
        end
      end

      assign out_vld  = stg_v[STAGES-1];
      assign out_data = stg_d[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ordram_top.sv
module ordram_top
  import ordram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 72,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);

  localparam int EXTRA = RD_LAT - 1;

  generate
    if (RD_LAT < LAT_MIN || RD_LAT > LAT_MAX) begin : g_bad_lat
      $error("ordram_top: RD_LAT must lie between 1 and 4");
    end
  endgenerate

  port_op_e          a_op, b_op;
  logic [DATA_W-1:0] a_q, b_q;
  logic              a_qv, b_qv;

  assign a_op = op_decode(a_en, a_we);
  assign b_op = op_decode(b_en, b_we);

  ordram_core #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .a_op    (a_op),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .b_op    (b_op),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .a_q     (a_q),
    .a_qv    (a_qv),
    .b_q     (b_q),
    .b_qv    (b_qv)
  );

  ordram_rdpipe #(
    .DATA_W (DATA_W),
    .STAGES (EXTRA)
  ) u_pipe_a (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (a_qv),
    .in_data  (a_q),
    .out_vld  (a_rvalid),
    .out_data (a_rdata)
  );

  ordram_rdpipe #(
    .DATA_W (DATA_W),
    .STAGES (EXTRA)
  ) u_pipe_b (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (b_qv),
    .in_data  (b_q),
    .out_vld  (b_rvalid),
    .out_data (b_rdata)
  );

endmodule

// File: rtl/ordram_checks.sv
module ordram_checks #(
  parameter int DATA_W = 72,
  parameter int RD_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic              a_we,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_rvalid,
  input logic              b_en,
  input logic              b_we,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_rvalid
);

  // Independent history of issued reads, one bit per cycle of latency.
  logic [RD_LAT-1:0] hist_a, hist_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_a <= '0;
      hist_b <= '0;
    end else begin
      hist_a <= (hist_a << 1) | RD_LAT'(a_en && !a_we);
      hist_b <= (hist_b << 1) | RD_LAT'(b_en && !b_we);
    end
  end

  // R3: one valid pulse, RD_LAT cycles after each read
  a_r3_lat_port_a: assert property (@(posedge clk) disable iff (rst)
    a_rvalid == hist_a[RD_LAT-1]);
  a_r3_lat_port_b: assert property (@(posedge clk) disable iff (rst)
    b_rvalid == hist_b[RD_LAT-1]);

  // R4: data holds whenever no read completes
  a_r4_hold_port_a: assert property (@(posedge clk) disable iff (rst)
    !a_rvalid |-> $stable(a_rdata));
  a_r4_hold_port_b: assert property (@(posedge clk) disable iff (rst)
    !b_rvalid |-> $stable(b_rdata));

  // R8: reset clears the outputs
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!a_rvalid && !b_rvalid && a_rdata == '0 && b_rdata == '0));

endmodule

bind ordram_top ordram_checks #(
  .DATA_W (DATA_W),
  .RD_LAT (RD_LAT)
) u_checks (.*);

// File: tb/ordram_top_bench.sv
module ordram_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst;
  logic          a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;

  logic [DW-1:0] s_ard, s_brd, f_ard, f_brd;
  logic          s_av, s_bv, f_av, f_bv;

  ordram_top #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(3)) u_ordram_top (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(s_ard), .a_rvalid(s_av),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(s_brd), .b_rvalid(s_bv)
  );

  ordram_top #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(1)) u_ordram_top_fast (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(f_ard), .a_rvalid(f_av),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(f_brd), .b_rvalid(f_bv)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] model [NW];
  logic [DW-1:0] h_sa, h_sb, h_fa, h_fb;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One access cycle on both ports, then a four-cycle observation window.
  task automatic xact(input bit ea, input bit wa, input logic [AW-1:0] aa,
                      input logic [DW-1:0] da,
                      input bit eb, input bit wb, input logic [AW-1:0] ab,
                      input logic [DW-1:0] db, input string req);
    bit ra, rb;
    logic [DW-1:0] xa, xb;
    ra = ea && !wa;
    rb = eb && !wb;
    xa = model[aa];
    xb = (ea && wa && aa == ab) ? da : model[ab];
    @(negedge clk);
    a_en = ea; a_we = wa; a_addr = aa; a_wdata = da;
    b_en = eb; b_we = wb; b_addr = ab; b_wdata = db;
    @(negedge clk);
    a_en = 1'b0; b_en = 1'b0;
    if (ea && wa) model[aa] = da;
    if (eb && wb) model[ab] = db;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      if (ra && i == 0) h_fa = xa;
      if (rb && i == 0) h_fb = xb;
      if (ra && i == 2) h_sa = xa;
      if (rb && i == 2) h_sb = xb;
      chk(f_av == (ra && i == 0), "R3", "lat1 A valid", DW'(f_av), DW'(ra && i == 0));
      chk(f_bv == (rb && i == 0), "R3", "lat1 B valid", DW'(f_bv), DW'(rb && i == 0));
      chk(s_av == (ra && i == 2), "R3", "lat3 A valid", DW'(s_av), DW'(ra && i == 2));
      chk(s_bv == (rb && i == 2), "R3", "lat3 B valid", DW'(s_bv), DW'(rb && i == 2));
      chk(f_ard == h_fa, req, "lat1 A data (R4 when held)", f_ard, h_fa);
      chk(f_brd == h_fb, req, "lat1 B data (R4 when held)", f_brd, h_fb);
      chk(s_ard == h_sa, req, "lat3 A data (R4 when held)", s_ard, h_sa);
      chk(s_brd == h_sb, req, "lat3 B data (R4 when held)", s_brd, h_sb);
    end
  endtask

  task automatic do_reset(input bit with_read);
    @(negedge clk);
    rst = 1'b1;
    a_en = with_read; a_we = 1'b0; b_en = with_read; b_we = 1'b0;
    @(negedge clk);
    a_en = 1'b0; b_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    h_sa = '0; h_sb = '0; h_fa = '0; h_fb = '0;
    // R8: outputs cleared, nothing in flight survives
    for (int i = 0; i < 4; i++) begin
      chk(!s_av && !s_bv && !f_av && !f_bv, "R8", "valid after reset",
          DW'({s_av, s_bv, f_av, f_bv}), '0);
      chk(s_ard == '0 && s_brd == '0, "R8", "lat3 data after reset", s_ard | s_brd, '0);
      chk(f_ard == '0 && f_brd == '0, "R8", "lat1 data after reset", f_ard | f_brd, '0);
      @(negedge clk);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * (13 + 2 * k) + 7 * k + 3);
  endfunction

  initial begin
    rst = 1'b1;
    a_en = 1'b0; a_we = 1'b0; a_addr = '0; a_wdata = '0;
    b_en = 1'b0; b_we = 1'b0; b_addr = '0; b_wdata = '0;
    do_reset(1'b0);

    // R1: write through A, read through B; then the reverse
    for (int a = 0; a < NW; a++) xact(1, 1, AW'(a), pat(a, 0), 0, 0, '0, '0, "R1");
    for (int a = 0; a < NW; a++) xact(0, 0, '0, '0, 1, 0, AW'(a), '0, "R1");
    for (int a = 0; a < NW; a++) xact(0, 0, '0, '0, 1, 1, AW'(a), pat(a, 1), "R1");
    for (int a = 0; a < NW; a++) xact(1, 0, AW'(a), '0, 0, 0, '0, '0, "R1");

    // R9: ports at different addresses in the same cycle
    for (int a = 0; a < NW; a++)
      xact(1, 1, AW'(a), pat(a, 2), 1, 0, AW'(NW - 1 - a), '0, "R9");
    for (int a = 0; a < NW; a++)
      xact(1, 0, AW'(a), '0, 1, 0, AW'(NW - 1 - a), '0, "R9");

    // R5: A writes, B reads same address
    for (int a = 0; a < NW; a++) xact(1, 1, AW'(a), pat(a, 3), 1, 0, AW'(a), '0, "R5");
    // R6: A reads, B writes same address
    for (int a = 0; a < NW; a++) xact(1, 0, AW'(a), '0, 1, 1, AW'(a), pat(a, 4), "R6");
    for (int a = 0; a < NW; a++) xact(1, 0, AW'(a), '0, 0, 0, '0, '0, "R6");
    // R7: both write same address, B's data remains
    for (int a = 0; a < NW; a++)
      xact(1, 1, AW'(a), pat(a, 5), 1, 1, AW'(a), pat(a, 6), "R7");
    for (int a = 0; a < NW; a++) xact(1, 0, AW'(a), '0, 1, 0, AW'(a), '0, "R7");

    // R2: disabled ports with write-enable high must not write or read
    for (int a = 0; a < NW; a += 3) begin
      xact(0, 1, AW'(a), 8'h5A, 0, 1, AW'(a), 8'hC3, "R2");
      xact(1, 0, AW'(a), '0, 1, 0, AW'(a), '0, "R2");
    end

    // R8: reset with reads in flight, then memory still usable
    xact(1, 0, 4'd2, '0, 1, 0, 4'd9, '0, "R1");
    do_reset(1'b1);
    xact(1, 1, 4'd4, 8'h77, 0, 0, '0, '0, "R1");
    xact(0, 0, '0, '0, 1, 0, 4'd4, '0, "R1");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule